// File: doc/BRIEF.md
# Address Translation Window Table

This block maps an address arriving on one of several source ports into a destination address space. Each source port owns a small group of programmable window entries. An entry describes a naturally aligned window of the source space: a source base, a translation base, a compact power-of-two size code, an enable flag, a pass-through flag and a destination identifier. A lookup supplies a port number and an address. The block answers one clock later with a hit flag, the translated address and the destination identifier of the winning entry.

A simple write port loads entries one 64-bit word at a time, and a read port returns any stored word. Each entry has three words: a source-parameter word, a translation base and a translation-parameter word. An entry is found by port index times the number of entries per port plus the entry index. There are six source ports. Ports 0 and 1 face the host PCI side and ports 2 to 5 are AXI slave ports. The block only computes the translation. Bus protocol, data movement and error responses belong to the surrounding logic.

Top module: `atw_table`

## Requirements
- R1: After reset every entry word reads as zero, so every entry is disabled, and `res_valid` and `rd_valid` are low.
- R2: In the source-parameter word (field code 0), bit 0 is the enable and bits [6:1] are a size code c. An enabled entry covers 2^(c+1) bytes, and any c of 63 or more covers the whole address space. The source base is bits [63:12] of the word, with the low 12 bits taken as zero. An address matches when its bits at or above the window size equal the base bits at or above the window size.
- R3: On a non-pass-through hit, the address bits below the window size come unchanged from the lookup address. The bits above the window size come from the translation base (field code 1), whose low 12 bits are taken as zero.
- R4: When bit 8 of the translation-parameter word (field code 2) is set and the entry is enabled, the entry matches every address and returns the address unchanged.
- R5: A hit returns bits [2:0] of the translation-parameter word as the destination. The codes are 0 for PCI transactions, 1 for PCI configuration, and 4 to 7 for AXI master ports 0 to 3. Codes 2 and 3 are unused and are passed through as stored.
- R6: When several enabled entries of a port match, the lowest-numbered entry wins.
- R7: With no matching enabled entry, or with a port number of 6 or more, the result has hit low, the address unchanged and destination 0.
- R8: Writing zero to an entry's source-parameter word disables the entry.
- R9: A lookup presented with `lk_valid` high produces its result, with `res_valid` high, on the next clock. A write made in the same cycle as a lookup does not affect that lookup.
- R10: A read returns the last word written to the addressed port, entry and field on the next clock, with `rd_valid` high. Field code 3 and ports of 6 or more read as zero, and writes to them are ignored.
- R11: The entries of one port never affect lookups on another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_port | input | 3 | Port index of the written entry |
| wr_entry | input | 2 | Entry index within the port |
| wr_field | input | 2 | Word select: 0 source param, 1 translation base, 2 translation param |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_port | input | 3 | Port index to read |
| rd_entry | input | 2 | Entry index to read |
| rd_field | input | 2 | Word select for the read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| lk_valid | input | 1 | Lookup request |
| lk_port | input | 3 | Source port of the lookup |
| lk_addr | input | 64 | Source address |
| res_valid | output | 1 | Result valid, one clock after the request |
| res_hit | output | 1 | A window matched |
| res_addr | output | 64 | Translated address |
| res_dest | output | 3 | Destination identifier |

## Verification
Every size code from 0 to 63 is swept once, with probes at the window base, at the top byte of the window, one past the top, one below the base and at a random offset inside. These probes separate off-by-one errors in the mask width from errors in the base comparison. The same probe addresses are then sent to a neighbouring port, which shows whether table slots leak across ports. Directed sequences stack four overlapping entries and disable them one at a time, which exposes priority and disable faults, and they mix pass-through entries with disabled ones. A long random phase combines writes, reads and lookups in the same cycle, including out-of-range ports and the unused field code, so that the write-versus-lookup ordering is exercised.

// File: rtl/atw_pkg.sv
package atw_pkg;
  // field selectors for the write and read ports
  typedef enum logic [1:0] {
    FLD_SRC    = 2'd0,
    FLD_TBASE  = 2'd1,
    FLD_TPARAM = 2'd2,
    FLD_NONE   = 2'd3
  } atw_field_e;

  // source-parameter word layout
  localparam int EN_BIT   = 0;
  localparam int CODE_LSB = 1;
  localparam int CODE_W   = 6;
  localparam int BASE_LSB = 12;

  // translation-parameter word layout
  localparam int DEST_W   = 3;
  localparam int XPAR_BIT = 8;

  // destination identifiers
  localparam logic [DEST_W-1:0] DST_PCI_TXN = 3'd0;
  localparam logic [DEST_W-1:0] DST_PCI_CFG = 3'd1;
  localparam logic [DEST_W-1:0] DST_AXIM0   = 3'd4;
  localparam logic [DEST_W-1:0] DST_AXIM3   = 3'd7;
endpackage

// File: rtl/atw_entry_match.sv
module atw_entry_match
  import atw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                       en,
  input  logic [CODE_W-1:0]          code,
  input  logic [ADDR_W-BASE_LSB-1:0] src_base,
  input  logic [ADDR_W-BASE_LSB-1:0] tr_base,
  input  logic                       xpar,
  input  logic [DEST_W-1:0]          dest_in,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit,
  output logic [ADDR_W-1:0]          out_addr,
  output logic [DEST_W-1:0]          dest
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [CODE_W:0]   span;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] above;
  logic [ADDR_W-1:0] src_full;
  logic [ADDR_W-1:0] tr_full;
  logic              win_match;

  always_comb begin
    span = {1'b0, code} + (CODE_W+1)'(1);
    if (int'(span) >= ADDR_W) low_mask = '1;
    else                      low_mask = (ONE << span) - ONE;
    above     = ~low_mask;
    src_full  = {src_base, {BASE_LSB{1'b0}}};
    tr_full   = {tr_base,  {BASE_LSB{1'b0}}};
    win_match = (addr & above) == (src_full & above);
    hit       = en & (xpar | win_match);
    out_addr  = xpar ? addr : ((tr_full & above) | (addr & low_mask));
    dest      = dest_in;
  end
endmodule

// File: rtl/atw_prio_pick.sv
module atw_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/atw_table.sv
module atw_table
  import atw_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int N_PORTS = 6,
  parameter int N_ENT   = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic [((N_PORTS>1)?$clog2(N_PORTS):1)-1:0] wr_port,
  input  logic [((N_ENT>1)?$clog2(N_ENT):1)-1:0]     wr_entry,
  input  logic [1:0]                             wr_field,
  input  logic [ADDR_W-1:0]                      wr_data,
  input  logic                                   rd_en,
  input  logic [((N_PORTS>1)?$clog2(N_PORTS):1)-1:0] rd_port,
  input  logic [((N_ENT>1)?$clog2(N_ENT):1)-1:0]     rd_entry,
  input  logic [1:0]                             rd_field,
  output logic                                   rd_valid,
  output logic [ADDR_W-1:0]                      rd_data,
  input  logic                                   lk_valid,
  input  logic [((N_PORTS>1)?$clog2(N_PORTS):1)-1:0] lk_port,
  input  logic [ADDR_W-1:0]                      lk_addr,
  output logic                                   res_valid,
  output logic                                   res_hit,
  output logic [ADDR_W-1:0]                      res_addr,
  output logic [DEST_W-1:0]                      res_dest
);
  localparam int PORT_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int ENT_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int N_SLOTS = N_PORTS * N_ENT;
  localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [PORT_W-1:0] p,
                                                 input logic [ENT_W-1:0] e);
    return SLOT_W'(int'(p) * N_ENT + int'(e));
  endfunction

  // entry storage: three words per slot
  logic [ADDR_W-1:0] src_mem [N_SLOTS];
  logic [ADDR_W-1:0] tb_mem  [N_SLOTS];
  logic [ADDR_W-1:0] tp_mem  [N_SLOTS];

  logic              wr_ok;
  logic [SLOT_W-1:0] wslot;
  assign wr_ok = wr_en && (int'(wr_port) < N_PORTS) && (int'(wr_entry) < N_ENT);
  assign wslot = slot_of(wr_port, wr_entry);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SLOTS; i++) begin
        src_mem[i] <= '0;
        tb_mem[i]  <= '0;
        tp_mem[i]  <= '0;
      end
    end else if (wr_ok) begin
      case (atw_field_e'(wr_field))
        FLD_SRC:    src_mem[wslot] <= wr_data;
        FLD_TBASE:  tb_mem[wslot]  <= wr_data;
        FLD_TPARAM: tp_mem[wslot]  <= wr_data;
        default:    ;
      endcase
    end
  end

  // readback
  logic              rd_ok;
  logic [SLOT_W-1:0] rslot;
  assign rd_ok = (int'(rd_port) < N_PORTS) && (int'(rd_entry) < N_ENT);
  assign rslot = slot_of(rd_port, rd_entry);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (!rd_ok) rd_data <= '0;
        else begin
          case (atw_field_e'(rd_field))
            FLD_SRC:    rd_data <= src_mem[rslot];
            FLD_TBASE:  rd_data <= tb_mem[rslot];
            FLD_TPARAM: rd_data <= tp_mem[rslot];
            default:    rd_data <= '0;
          endcase
        end
      end
    end
  end

  // lookup: all entries of the selected port are compared in parallel
  logic              lk_port_ok;
  logic [PORT_W-1:0] lk_port_c;
  assign lk_port_ok = int'(lk_port) < N_PORTS;
  assign lk_port_c  = lk_port_ok ? lk_port : '0;

  logic [N_ENT-1:0]  ent_hit;
  logic [N_ENT-1:0]  ent_gnt;
  logic [ADDR_W-1:0] ent_addr [N_ENT];
  logic [DEST_W-1:0] ent_dest [N_ENT];
  logic              any_hit;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [SLOT_W-1:0] s;
    assign s = slot_of(lk_port_c, ENT_W'(e));
    atw_entry_match #(.ADDR_W(ADDR_W)) u_match (
      .en       (src_mem[s][EN_BIT]),
      .code     (src_mem[s][CODE_LSB +: CODE_W]),
      .src_base (src_mem[s][ADDR_W-1:BASE_LSB]),
      .tr_base  (tb_mem[s][ADDR_W-1:BASE_LSB]),
      .xpar     (tp_mem[s][XPAR_BIT]),
      .dest_in  (tp_mem[s][DEST_W-1:0]),
      .addr     (lk_addr),
      .hit      (ent_hit[e]),
      .out_addr (ent_addr[e]),
      .dest     (ent_dest[e])
    );
  end

  atw_prio_pick #(.N(N_ENT)) u_pick (
    .req (ent_hit),
    .gnt (ent_gnt),
    .any (any_hit)
  );

  logic [ADDR_W-1:0] sel_addr;
  logic [DEST_W-1:0] sel_dest;
  always_comb begin
    sel_addr = '0;
    sel_dest = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (ent_gnt[e]) begin
        sel_addr |= ent_addr[e];
        sel_dest |= ent_dest[e];
      end
    end
  end

  logic take;
  assign take = any_hit && lk_port_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_addr  <= '0;
      res_dest  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= take;
      res_addr  <= take ? sel_addr : lk_addr;
      res_dest  <= take ? sel_dest : '0;
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ent_gnt)) else $error("more than one entry granted"); // R6
  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid) else $error("result missing"); // R9
  AST_IDLE_NO_RES: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid) else $error("spurious result"); // R9
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (res_hit || (res_addr == $past(lk_addr) && res_dest == '0)))
    else $error("miss altered address or destination"); // R7
  AST_BAD_PORT_MISS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (int'(lk_port) >= N_PORTS)) |=> !res_hit)
    else $error("hit on nonexistent port"); // R7
  AST_LSB_KEPT: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (res_addr[0] == $past(lk_addr[0])))
    else $error("byte offset bit changed"); // R3
  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid) else $error("read data missing"); // R10
endmodule

// File: tb/tb_atw_table.sv
`timescale 1ns/1ps
module tb_atw_table;
  import atw_pkg::*;
  localparam int NP = 6;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, rd_en = 0, lk_valid = 0;
  logic [2:0]  wr_port = 0, rd_port = 0, lk_port = 0;
  logic [1:0]  wr_entry = 0, rd_entry = 0;
  logic [1:0]  wr_field = 0, rd_field = 0;
  logic [63:0] wr_data = 0, lk_addr = 0;
  logic        rd_valid, res_valid, res_hit;
  logic [63:0] rd_data, res_addr;
  logic [2:0]  res_dest;

  always #4 clk = ~clk; // 125 MHz

  atw_table dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_port(wr_port), .wr_entry(wr_entry), .wr_field(wr_field), .wr_data(wr_data),
    .rd_en(rd_en), .rd_port(rd_port), .rd_entry(rd_entry), .rd_field(rd_field),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .lk_valid(lk_valid), .lk_port(lk_port), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr), .res_dest(res_dest)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
  logic [63:0] sh_src [NP*NE];
  logic [63:0] sh_tb  [NP*NE];
  logic [63:0] sh_tp  [NP*NE];

  function logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic logic [63:0] wmask(input int c);
    if (c >= 63) return '1;
    return (64'd1 << (c + 1)) - 64'd1;
  endfunction

  // expected lookup from the requirements
  function automatic void model(input int p, input logic [63:0] a,
                                output bit h, output logic [63:0] o, output logic [2:0] d);
    h = 0; o = a; d = 3'd0;
    if (p >= NP) return;
    for (int e = 0; e < NE; e++) begin
      logic [63:0] s, m, bm;
      s = sh_src[p*NE+e];
      if (!s[0]) continue;
      m  = wmask(int'(s[6:1]));
      bm = ~m & ~64'hFFF;
      if (sh_tp[p*NE+e][8]) begin
        h = 1; o = a; d = sh_tp[p*NE+e][2:0]; return;
      end
      if ((a & ~m) == (s & bm)) begin
        h = 1; o = (sh_tb[p*NE+e] & bm) | (a & m); d = sh_tp[p*NE+e][2:0]; return;
      end
    end
  endfunction

  function automatic logic [63:0] shread(input int p, input int e, input int f);
    if (p >= NP) return 64'd0;
    case (f)
      0: return sh_src[p*NE+e];
      1: return sh_tb[p*NE+e];
      2: return sh_tp[p*NE+e];
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [71:0] got, input logic [71:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock of stimulus: optional write, lookup and read together
  task automatic op(input bit dw, input int wp, input int we, input int wf, input logic [63:0] wd,
                    input bit dl, input int lp, input logic [63:0] la,
                    input bit dr, input int rp, input int re, input int rf, input string tag);
    bit eh; logic [63:0] ea; logic [2:0] ed; logic [63:0] erd;
    model(lp, la, eh, ea, ed);
    erd = shread(rp, re, rf);
    wr_en = dw; wr_port = wp[2:0]; wr_entry = we[1:0]; wr_field = wf[1:0]; wr_data = wd;
    lk_valid = dl; lk_port = lp[2:0]; lk_addr = la;
    rd_en = dr; rd_port = rp[2:0]; rd_entry = re[1:0]; rd_field = rf[1:0];
    @(posedge clk);
    if (dw && wp < NP && wf < 3) begin
      if (wf == 0) sh_src[wp*NE+we] = wd;
      else if (wf == 1) sh_tb[wp*NE+we] = wd;
      else sh_tp[wp*NE+we] = wd;
    end
    @(negedge clk);
    wr_en = 0; lk_valid = 0; rd_en = 0;
    if (dl) chk(tag, {4'd0, res_valid, res_hit, res_addr, res_dest}, {4'd0, 1'b1, eh, ea, ed});
    if (dr) chk(tag, {7'd0, rd_valid, rd_data}, {7'd0, 1'b1, erd});
  endtask

  task automatic wr(input int p, input int e, input int f, input logic [63:0] d);
    op(1, p, e, f, d, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic lk(input int p, input logic [63:0] a, input string tag);
    op(0, 0, 0, 0, 0, 1, p, a, 0, 0, 0, 0, tag);
  endtask
  task automatic rd(input int p, input int e, input int f, input string tag);
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, p, e, f, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NP*NE; i++) begin sh_src[i] = 0; sh_tb[i] = 0; sh_tp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1", {70'd0, res_valid, rd_valid}, 72'd0);
    for (int p = 0; p < NP; p++)
      for (int e = 0; e < NE; e++) rd(p, e, 0, "R1");
    lk(0, 64'h0, "R1");
    lk(3, 64'hDEAD_BEEF_0000_1000, "R1");

    // size-code sweep
    for (int c = 0; c < 64; c++) begin
      int p, e, q;
      logic [63:0] m, bm, base, tb;
      p = c % NP; e = c % NE; q = (p + 1) % NP;
      m = wmask(c); bm = ~m & ~64'hFFF;
      base = rnd() & bm; tb = rnd() & bm;
      wr(p, e, 2, 64'(c % 8));
      wr(p, e, 1, tb);
      wr(p, e, 0, base | (64'(c) << 1) | 64'd1);
      rd(p, e, 0, "R10");
      lk(p, base, "R2");
      lk(p, base | m, "R2");
      lk(p, base + m + 64'd1, "R2");
      lk(p, base - 64'd1, "R2");
      lk(p, base | (rnd() & m), "R3");
      lk(q, base | (rnd() & m), "R11");
      wr(p, e, 0, 64'd0);
      lk(p, base, "R8");
    end

    // priority among overlapping entries, removed one at a time
    for (int e = 0; e < NE; e++) begin
      wr(2, e, 1, 64'(e + 1) << 40);
      wr(2, e, 2, 64'(4 + e));
      wr(2, e, 0, 64'h0000_0055_0000_0000 | (64'd23 << 1) | 64'd1);
    end
    for (int e = 0; e < NE; e++) begin
      lk(2, 64'h0000_0055_0012_3456, "R6");
      lk(2, 64'h0000_0055_00FF_FFFF, "R5");
      wr(2, e, 0, 64'd0);
      rd(2, e, 0, "R8");
    end
    lk(2, 64'h0000_0055_0012_3456, "R8");

    // pass-through entries
    wr(5, 0, 1, 64'h1234_0000_0000_0000);
    wr(5, 0, 0, 64'h0000_7000_0000_0000 | (64'd11 << 1) | 64'd1);
    wr(5, 1, 2, 64'h100 | 64'(DST_PCI_CFG));
    wr(5, 1, 0, 64'h1 | (64'd3 << 1));
    for (int i = 0; i < 8; i++) lk(5, rnd(), "R4");
    lk(5, 64'h0000_7000_0000_0ABC, "R6");
    wr(5, 1, 0, 64'h0000_0000_0000_0006);
    for (int i = 0; i < 4; i++) lk(5, rnd(), "R4");
    lk(6, 64'h0000_7000_0000_0ABC, "R7");
    lk(7, 64'h0, "R7");
    wr(6, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(6, 0, 0, "R10");
    wr(1, 3, 3, 64'hFFFF);
    rd(1, 3, 3, "R10");
    rd(1, 3, 0, "R10");

    // same-cycle write and lookup: lookup sees the old contents
    wr(0, 0, 1, 64'hAAAA_0000_0000_0000);
    wr(0, 0, 2, 64'(DST_AXIM0));
    op(1, 0, 0, 0, 64'h0000_0000_4000_0000 | (64'd29 << 1) | 64'd1,
       1, 0, 64'h0000_0000_4000_1234, 0, 0, 0, 0, "R9");
    lk(0, 64'h0000_0000_4000_1234, "R9");
    op(1, 0, 0, 0, 64'd0, 1, 0, 64'h0000_0000_4000_1234, 1, 0, 0, 0, "R9");
    lk(0, 64'h0000_0000_4000_1234, "R8");

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit dw, dl, dr;
      int wp, we, wf, lp, sl;
      logic [63:0] wd, la;
      dw = (rnd() % 3) == 0;
      dl = (rnd() % 4) != 0;
      dr = (rnd() % 3) == 0;
      wp = int'(rnd() % 8); we = int'(rnd() % 4); wf = int'(rnd() % 4);
      if (wf == 0) begin
        int c;
        c = ((rnd() % 8) == 0) ? int'(rnd() % 64) : int'(rnd() % 22);
        wd = (rnd() & ~64'h7F) | (64'(c) << 1) | 64'((rnd() % 5) != 0);
      end else if (wf == 2) begin
        wd = ((rnd() % 10) == 0) ? rnd() : (rnd() & ~64'h100);
      end else wd = rnd();
      lp = int'(rnd() % 8);
      sl = int'(rnd() % (NP*NE));
      if ((rnd() % 4) == 0) la = rnd();
      else la = (sh_src[sl] & ~64'hFFF) ^ (rnd() & ((64'd1 << (rnd() % 24)) - 64'd1));
      op(dw, wp, we, wf, wd, dl, lp, la, dr, int'(rnd() % 8), int'(rnd() % 4),
         int'(rnd() % 4), (dw && dl) ? "R9" : "R3");
    end

    finish_run();
  end
endmodule